// File: doc/BRIEF.md
# Result Latency Interlock Scoreboard

This block tracks, for every architectural register, how many cycles remain before the value most recently dispatched to it can be read. When a producer is dispatched, its class selects a countdown for its destination register. Each countdown then drops by one per cycle. A consumer presents two source register indices, its own class, and a flag that says which source carries store data. The block answers in the same cycle with a stall flag and a per-source ready flag.

The required distance between producer and consumer depends on both classes. Floating-point arithmetic results reach another floating-point add or multiply one cycle early. Store data may be taken from a producer dispatched in the same cycle, unless that producer is a divide or square root. A conditional branch may sit in the same cycle as the integer compare that sets its flags. The integration gives condition flags a register index of their own, and a branch names that index on its first source. The register file and datapath lie outside this block.

A producer dispatched in a cycle is visible to a consumer presented in that same cycle, because the consumer is taken as later in program order.

Top module: `latency_scoreboard`

## Requirements
- R1: After reset every bit of `reg_rdy` is 1, and a consumer naming any registers does not stall.
- R2: Register index 0 is always ready. A dispatch to index 0 changes no state, and a consumer whose sources are both 0 never stalls.
- R3: Producer classes integer ALU (0), shift (1), integer compare (2), FP move (3) and FP compare (4) are usable 1 cycle after dispatch. A consumer in the dispatch cycle stalls for exactly 1 cycle.
- R4: Unsigned or FP load (5) and conditional move (7, integer; 8, FP) need 2 cycles. Sign-extending load (6) needs 3 cycles.
- R5: FP add/subtract (9) and FP multiply (10) need 4 cycles to a general consumer, but only 3 to an FP-arithmetic consumer (consumer class 1). No other producer class gets this shortening.
- R6: Single-precision divide/sqrt (11) needs 13 cycles in general and 12 to an FP-arithmetic consumer. Double-precision divide/sqrt (12) needs 23 and 22.
- R7: For a store consumer (class 2), the source chosen by `use_data_sel` (0 = source A, 1 = source B) is ready at once, even in the dispatch cycle, for any producer except classes 11 and 12. The other source, the address, follows the general latency.
- R8: A branch consumer (class 3) does not stall on a register written by an integer compare (2), even in the dispatch cycle. An FP compare (4) still costs it 1 cycle.
- R9: A new dispatch to a register replaces that register's pending countdown and class, even if the older one has not finished.
- R10: `stall` is high exactly when `use_valid` is high and at least one source is not ready. `reg_rdy[i]` reports general readiness from the registered state only, so it does not yet reflect a dispatch made in the current cycle. Consumer classes: 0 general, 1 FP arithmetic, 2 store, 3 branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | A producer is dispatched this cycle |
| iss_dst | input | IDX_W | Destination register of the producer |
| iss_cls | input | 4 | Producer class code |
| use_valid | input | 1 | A consumer is presented this cycle |
| use_cls | input | 2 | Consumer class code |
| use_src_a | input | IDX_W | First source register |
| use_src_b | input | IDX_W | Second source register |
| use_data_sel | input | 1 | Which source is store data (0 = A, 1 = B) |
| stall | output | 1 | Consumer must wait |
| src_a_rdy | output | 1 | Source A may be read this cycle |
| src_b_rdy | output | 1 | Source B may be read this cycle |
| reg_rdy | output | NREGS | Per-register general readiness, from the registered state |

## Verification
A producer dispatched in cycle t with effective latency L holds `stall` high in cycles t through t+L-1 and lets it fall in cycle t+L. `reg_rdy` for that register falls in cycle t+1 and rises in cycle t+L. The bench presents the consumer in the same cycle as the dispatch. It samples `stall` one nanosecond after each falling edge and counts the stalled cycles until the first free one, so every latency comes out as an exact count, with zero for the bypass cases. `reg_rdy` is sampled at the same offset in the dispatch cycle and in the two cycles after it.

// File: rtl/lsb_pkg.sv
package lsb_pkg;
    localparam int unsigned LAT_ONE   = 1;
    localparam int unsigned LAT_LOAD  = 2;
    localparam int unsigned LAT_SLOAD = 3;
    localparam int unsigned LAT_CMOV  = 2;
    localparam int unsigned LAT_FPOP  = 4;
    localparam int unsigned LAT_FDIVS = 13;
    localparam int unsigned LAT_FDIVD = 23;
    localparam int unsigned LAT_MAX   = (LAT_FDIVD > LAT_FDIVS) ? LAT_FDIVD : LAT_FDIVS;
    localparam int unsigned CNT_W     = $clog2(LAT_MAX + 1);

    typedef enum logic [3:0] {
        P_IALU  = 4'd0,
        P_SHIFT = 4'd1,
        P_CMP   = 4'd2,
        P_FMOV  = 4'd3,
        P_FCMP  = 4'd4,
        P_LOAD  = 4'd5,
        P_SLOAD = 4'd6,
        P_CMOV  = 4'd7,
        P_FCMOV = 4'd8,
        P_FADD  = 4'd9,
        P_FMUL  = 4'd10,
        P_FDIVS = 4'd11,
        P_FDIVD = 4'd12
    } pcls_e;

    typedef enum logic [1:0] {
        U_GEN    = 2'd0,
        U_FPAR   = 2'd1,
        U_STORE  = 2'd2,
        U_BRANCH = 2'd3
    } ucls_e;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [3:0]       cls;
    } ent_t;
endpackage

// File: rtl/lsb_lat_table.sv
module lsb_lat_table
    import lsb_pkg::*;
(
    input  logic [3:0]       cls,
    output logic [CNT_W-1:0] lat
);
    always_comb begin
        case (cls)
            P_LOAD:          lat = CNT_W'(LAT_LOAD);
            P_SLOAD:         lat = CNT_W'(LAT_SLOAD);
            P_CMOV, P_FCMOV: lat = CNT_W'(LAT_CMOV);
            P_FADD, P_FMUL:  lat = CNT_W'(LAT_FPOP);
            P_FDIVS:         lat = CNT_W'(LAT_FDIVS);
            P_FDIVD:         lat = CNT_W'(LAT_FDIVD);
            default:         lat = CNT_W'(LAT_ONE);
        endcase
    end
endmodule

// File: rtl/lsb_src_gate.sv
module lsb_src_gate
    import lsb_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] src,
    input  logic             is_data,
    input  logic [1:0]       use_cls,
    input  logic             iss_valid,
    input  logic [IDX_W-1:0] iss_dst,
    input  logic [3:0]       iss_cls,
    input  logic [CNT_W-1:0] iss_lat,
    input  logic [CNT_W-1:0] ent_cnt,
    input  logic [3:0]       ent_cls,
    output logic             rdy
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic             hit;
    logic [CNT_W-1:0] cnt_v;
    logic [3:0]       cls_v;
    logic             fp_src;
    logic             div_src;
    logic             data_byp;
    logic             br_byp;
    logic             fp_byp;

    always_comb begin
        // a producer dispatched this cycle precedes the consumer
        hit      = iss_valid && (iss_dst == src);
        cnt_v    = hit ? iss_lat : ent_cnt;
        cls_v    = hit ? iss_cls : ent_cls;
        div_src  = (cls_v == P_FDIVS) || (cls_v == P_FDIVD);
        fp_src   = (cls_v == P_FADD) || (cls_v == P_FMUL) || div_src;
        data_byp = is_data && !div_src;
        br_byp   = (use_cls == U_BRANCH) && (cls_v == P_CMP);
        fp_byp   = (use_cls == U_FPAR) && fp_src && (cnt_v == ONE);
        rdy      = (src == '0) || (cnt_v == '0) || data_byp || br_byp || fp_byp;
    end
endmodule

// File: rtl/latency_scoreboard.sv
module latency_scoreboard
    import lsb_pkg::*;
#(
    parameter  int NREGS = 32,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_valid,
    input  logic [IDX_W-1:0] iss_dst,
    input  logic [3:0]       iss_cls,
    input  logic             use_valid,
    input  logic [1:0]       use_cls,
    input  logic [IDX_W-1:0] use_src_a,
    input  logic [IDX_W-1:0] use_src_b,
    input  logic             use_data_sel,
    output logic             stall,
    output logic             src_a_rdy,
    output logic             src_b_rdy,
    output logic [NREGS-1:0] reg_rdy
);
    localparam int               NSRC = 2;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    ent_t [NREGS-1:0]            tab_d, tab_q;
    logic [CNT_W-1:0]            iss_lat;
    logic [NSRC-1:0][IDX_W-1:0]  src_v;
    logic [NSRC-1:0]             src_rdy;

    lsb_lat_table i_lat (
        .cls (iss_cls),
        .lat (iss_lat)
    );

    always_comb begin
        tab_d = tab_q;
        for (int i = 0; i < NREGS; i++) begin
            if (tab_q[i].cnt != '0) tab_d[i].cnt = tab_q[i].cnt - ONE;
        end
        // newest producer replaces any older countdown
        if (iss_valid && (iss_dst != '0)) begin
            tab_d[iss_dst].cnt = iss_lat - ONE;
            tab_d[iss_dst].cls = iss_cls;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tab_q <= '0;
        else        tab_q <= tab_d;
    end

    assign src_v = {use_src_b, use_src_a};

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        logic data_s;
        assign data_s = (use_cls == U_STORE) && (use_data_sel == 1'(s));
        lsb_src_gate #(.IDX_W(IDX_W)) i_gate (
            .src       (src_v[s]),
            .is_data   (data_s),
            .use_cls   (use_cls),
            .iss_valid (iss_valid),
            .iss_dst   (iss_dst),
            .iss_cls   (iss_cls),
            .iss_lat   (iss_lat),
            .ent_cnt   (tab_q[src_v[s]].cnt),
            .ent_cls   (tab_q[src_v[s]].cls),
            .rdy       (src_rdy[s])
        );
    end

    for (genvar g = 0; g < NREGS; g++) begin : g_rdy
        if (g == 0) begin : g_zero
            assign reg_rdy[g] = 1'b1;
        end else begin : g_reg
            assign reg_rdy[g] = (tab_q[g].cnt == '0);
        end
    end

    assign src_a_rdy = src_rdy[0];
    assign src_b_rdy = src_rdy[1];
    assign stall     = use_valid && !(&src_rdy);
endmodule

// File: rtl/lsb_checker.sv
module lsb_checker
    import lsb_pkg::*;
#(
    parameter int NREGS = 32,
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             iss_valid,
    input logic [IDX_W-1:0] iss_dst,
    input logic [3:0]       iss_cls,
    input logic             use_valid,
    input logic [1:0]       use_cls,
    input logic [IDX_W-1:0] use_src_a,
    input logic [IDX_W-1:0] use_src_b,
    input logic             use_data_sel,
    input logic             stall,
    input logic [NREGS-1:0] reg_rdy
);
    logic short_cls;
    logic long_cls;
    assign short_cls = iss_cls inside {P_IALU, P_SHIFT, P_CMP, P_FMOV, P_FCMP};
    assign long_cls  = iss_cls inside {P_LOAD, P_SLOAD, P_CMOV, P_FCMOV,
                                       P_FADD, P_FMUL, P_FDIVS, P_FDIVD};

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (&reg_rdy));

    p_zero_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (use_valid && use_src_a == '0 && use_src_b == '0) |-> !stall);

    p_short_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_dst != '0 && short_cls) |=> reg_rdy[$past(iss_dst)]);

    p_long_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_dst != '0 && long_cls) |=> !reg_rdy[$past(iss_dst)]);

    p_store_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_dst != '0 && use_valid && use_cls == U_STORE &&
         use_data_sel && use_src_b == '0 && use_src_a == iss_dst) |-> stall);

    p_cmp_branch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_cls == P_CMP && use_valid && use_cls == U_BRANCH &&
         use_src_a == iss_dst && use_src_b == '0) |-> !stall);

    for (genvar g = 0; g < NREGS; g++) begin : g_hold
        p_ready_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_rdy[g] && !(iss_valid && iss_dst == IDX_W'(g))) |=> reg_rdy[g]);
    end
endmodule

bind latency_scoreboard lsb_checker #(.NREGS(NREGS), .IDX_W(IDX_W)) i_lsb_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .iss_valid    (iss_valid),
    .iss_dst      (iss_dst),
    .iss_cls      (iss_cls),
    .use_valid    (use_valid),
    .use_cls      (use_cls),
    .use_src_a    (use_src_a),
    .use_src_b    (use_src_b),
    .use_data_sel (use_data_sel),
    .stall        (stall),
    .reg_rdy      (reg_rdy)
);

// File: tb/test_latency_scoreboard.sv
`timescale 1ns/1ps
module test_latency_scoreboard;
    import lsb_pkg::*;

    localparam int NREGS = 32;
    localparam int IDX_W = $clog2(NREGS);
    localparam logic [IDX_W-1:0] RD = IDX_W'(9);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             iss_valid = 1'b0;
    logic [IDX_W-1:0] iss_dst = '0;
    logic [3:0]       iss_cls = '0;
    logic             use_valid = 1'b0;
    logic [1:0]       use_cls = '0;
    logic [IDX_W-1:0] use_src_a = '0;
    logic [IDX_W-1:0] use_src_b = '0;
    logic             use_data_sel = 1'b0;
    logic             stall;
    logic             src_a_rdy;
    logic             src_b_rdy;
    logic [NREGS-1:0] reg_rdy;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 0;

    always #2.5 clk = ~clk;

    latency_scoreboard #(.NREGS(NREGS)) i_latency_scoreboard (
        .clk          (clk),
        .rst_n        (rst_n),
        .iss_valid    (iss_valid),
        .iss_dst      (iss_dst),
        .iss_cls      (iss_cls),
        .use_valid    (use_valid),
        .use_cls      (use_cls),
        .use_src_a    (use_src_a),
        .use_src_b    (use_src_b),
        .use_data_sel (use_data_sel),
        .stall        (stall),
        .src_a_rdy    (src_a_rdy),
        .src_b_rdy    (src_b_rdy),
        .reg_rdy      (reg_rdy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        iss_valid = 1'b0;
        use_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // dispatch producer to RD, present consumer in the same cycle, count stalled cycles
    task automatic lat_case(input logic [3:0] pc, input logic [1:0] uc, input logic dsel,
                            input logic on_b, input int expv, input string req);
        int  n = 0;
        bit  fin = 0;
        @(negedge clk);
        iss_valid    = 1'b1;
        iss_dst      = RD;
        iss_cls      = pc;
        use_valid    = 1'b1;
        use_cls      = uc;
        use_data_sel = dsel;
        use_src_a    = on_b ? '0 : RD;
        use_src_b    = on_b ? RD : '0;
        for (int k = 0; k < 40 && !fin; k++) begin
            #1;
            if (stall) n++;
            else fin = 1;
            if (!fin) begin
                @(negedge clk);
                iss_valid = 1'b0;
            end
        end
        check(n == expv, req, n, expv);
        idle(25);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        use_valid = 1'b1;
        use_cls   = U_GEN;
        use_src_a = IDX_W'(3);
        use_src_b = IDX_W'(17);
        #1;
        check(&reg_rdy, "R1 reg_rdy after reset", int'(&reg_rdy), 1);
        check(!stall, "R1 stall after reset", int'(stall), 0);
        idle(1);
    endtask

    task automatic t_zero_reg();
        @(negedge clk);
        iss_valid = 1'b1;
        iss_dst   = '0;
        iss_cls   = P_FDIVD;
        use_valid = 1'b1;
        use_cls   = U_GEN;
        use_src_a = '0;
        use_src_b = '0;
        #1;
        check(!stall, "R2 reg0 same cycle", int'(stall), 0);
        @(negedge clk);
        iss_valid = 1'b0;
        #1;
        check(&reg_rdy, "R2 reg_rdy after write to reg0", int'(&reg_rdy), 1);
        check(!stall, "R2 reg0 next cycle", int'(stall), 0);
        idle(1);
    endtask

    task automatic t_reg_rdy();
        @(negedge clk);
        iss_valid = 1'b1;
        iss_dst   = IDX_W'(3);
        iss_cls   = P_LOAD;
        use_valid = 1'b0;
        #1;
        check(reg_rdy[3] == 1'b1, "R10 reg_rdy in dispatch cycle", int'(reg_rdy[3]), 1);
        @(negedge clk);
        iss_valid = 1'b0;
        #1;
        check(reg_rdy[3] == 1'b0, "R10 reg_rdy one cycle later", int'(reg_rdy[3]), 0);
        @(negedge clk);
        #1;
        check(reg_rdy[3] == 1'b1, "R10 reg_rdy two cycles later", int'(reg_rdy[3]), 1);
        idle(1);
    endtask

    task automatic t_src_flags();
        // store with data on B from a divide and address on A ready: B not ready, A ready
        @(negedge clk);
        iss_valid    = 1'b1;
        iss_dst      = RD;
        iss_cls      = P_FDIVS;
        use_valid    = 1'b1;
        use_cls      = U_STORE;
        use_data_sel = 1'b1;
        use_src_a    = IDX_W'(4);
        use_src_b    = RD;
        #1;
        check(src_a_rdy && !src_b_rdy && stall, "R10 per-source flags",
              int'({src_a_rdy, src_b_rdy, stall}), 5);
        idle(25);
    endtask

    task automatic t_waw();
        @(negedge clk);
        iss_valid = 1'b1;
        iss_dst   = IDX_W'(7);
        iss_cls   = P_FDIVD;
        use_valid = 1'b0;
        @(negedge clk);
        iss_cls   = P_IALU;
        @(negedge clk);
        iss_valid = 1'b0;
        use_valid = 1'b1;
        use_cls   = U_GEN;
        use_src_a = IDX_W'(7);
        use_src_b = '0;
        #1;
        check(!stall && reg_rdy[7], "R9 newer producer replaces countdown",
              int'({stall, reg_rdy[7]}), 1);
        idle(25);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        t_reset();
        t_zero_reg();
        lat_case(P_IALU,  U_GEN,    1'b0, 1'b0, 1,  "R3 ialu to general");
        lat_case(P_SHIFT, U_GEN,    1'b0, 1'b0, 1,  "R3 shift to general");
        lat_case(P_FMOV,  U_FPAR,   1'b0, 1'b0, 1,  "R3 fmove to fp consumer");
        lat_case(P_LOAD,  U_GEN,    1'b0, 1'b0, 2,  "R4 load");
        lat_case(P_SLOAD, U_GEN,    1'b0, 1'b0, 3,  "R4 signed load");
        lat_case(P_SLOAD, U_FPAR,   1'b0, 1'b0, 3,  "R5 signed load no fp bypass");
        lat_case(P_CMOV,  U_GEN,    1'b0, 1'b0, 2,  "R4 int cond move");
        lat_case(P_FCMOV, U_GEN,    1'b0, 1'b0, 2,  "R4 fp cond move");
        lat_case(P_FADD,  U_GEN,    1'b0, 1'b0, 4,  "R5 fadd to general");
        lat_case(P_FADD,  U_FPAR,   1'b0, 1'b0, 3,  "R5 fadd to fp arith");
        lat_case(P_FMUL,  U_FPAR,   1'b0, 1'b0, 3,  "R5 fmul to fp arith");
        lat_case(P_FDIVS, U_GEN,    1'b0, 1'b0, 13, "R6 single div general");
        lat_case(P_FDIVS, U_FPAR,   1'b0, 1'b0, 12, "R6 single div to fp arith");
        lat_case(P_FDIVD, U_GEN,    1'b0, 1'b0, 23, "R6 double div general");
        lat_case(P_FDIVD, U_FPAR,   1'b0, 1'b0, 22, "R6 double div to fp arith");
        lat_case(P_IALU,  U_STORE,  1'b0, 1'b0, 0,  "R7 store data on A from ialu");
        lat_case(P_FMUL,  U_STORE,  1'b1, 1'b1, 0,  "R7 store data on B from fmul");
        lat_case(P_LOAD,  U_STORE,  1'b0, 1'b0, 0,  "R7 store data from load");
        lat_case(P_FDIVS, U_STORE,  1'b0, 1'b0, 13, "R7 store data from divide");
        lat_case(P_LOAD,  U_STORE,  1'b1, 1'b0, 2,  "R7 store address no bypass");
        lat_case(P_CMP,   U_BRANCH, 1'b0, 1'b0, 0,  "R8 compare to branch");
        lat_case(P_FCMP,  U_BRANCH, 1'b0, 1'b0, 1,  "R8 fp compare to branch");
        lat_case(P_CMP,   U_GEN,    1'b0, 1'b0, 1,  "R8 compare to general");
        t_reg_rdy();
        t_src_flags();
        t_waw();
        finish_run();
    end
endmodule